// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter in a small microcontroller. A conversion is started by a software write of the start bit, or by a rising edge on an external start pin when the external-trigger enable is set. The block then counts fixed phases in machine cycles: two cycles of initiation, eight cycles in which the sample-hold strobe is high, ten bit trials of four cycles each from the MSB down, and two closing cycles. It drives a trial code to an off-block DAC and reads back a single comparator bit.

All timing advances only on a one-clock machine-cycle enable pulse. The start bit is split in two. A command flop takes the write. A separate busy status flag shows whether a conversion is running. The finished result is presented as an upper byte and two low bits, and a done flag stays set until software clears it. Entry to a low-power mode abandons a running conversion but leaves an earlier completed result and its done flag untouched. A two-bit channel register drives the analog multiplexer select.

Top module: `sar_conv_seq`

## Requirements
- R1: A one-clock pulse on `sw_start` while idle starts a conversion at the first machine-cycle tick after it, whatever the value of `ext_en`.
- R2: With `ext_en`=1, a rising edge on `ext_start` (high and then low for at least 2 machine cycles each) is seen at a tick, and the conversion begins with the next cycle. With `ext_en`=0 the pin has no effect.
- R3: Counting the start tick as tick 0, `busy` is 0 right after tick 0 and becomes 1 after tick 1.
- R4: `sample_hold` is 1 after ticks 2 through 9 only, and `dac_code` is 0 while it is high.
- R5: Bit trials run MSB first. After tick 10+4j (j=0..9), `dac_code` holds the bits already decided with bit 9-j set and all lower bits clear. The first code is 10'h200. A tested bit is kept only when `cmp_in`=1 (input above DAC level). With `cmp_in` = (vin > dac_code), the result is vin-1 for vin≥1 and 0 for vin=0.
- R6: After tick 52, `done` becomes 1 and `busy` becomes 0. Before tick 52 `done` stays 0, and nothing advances between ticks.
- R7: `res_hi` carries result bits 9:2 and `res_lo` carries bits 1:0. Both are loaded only when a conversion completes.
- R8: A pulse on `chan_wr` loads `chan_wdata` into `chan_sel`.
- R9: A start from either source while a conversion runs does not disturb it, and it is not kept for later. `busy` stays 0 once that conversion ends.
- R10: A pulse on `lp_enter` during a conversion ends it: `busy` is 0 on the next clock, and `done` is not set. `done`, `res_hi` and `res_lo` from an earlier completed conversion are kept.
- R11: A pulse on `done_clr` clears `done`.
- R12: After reset, `busy`, `done`, `sample_hold`, `dac_code`, `res_hi`, `res_lo` and `chan_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | One-clock machine-cycle enable |
| sw_start | input | 1 | Software write of 1 to the start bit (pulse) |
| ext_en | input | 1 | External-trigger enable |
| ext_start | input | 1 | Asynchronous external start pin |
| chan_wr | input | 1 | Channel select write strobe |
| chan_wdata | input | 2 | Channel select write data |
| done_clr | input | 1 | Software write of 0 to the done flag (pulse) |
| lp_enter | input | 1 | Idle or power-down entry (pulse) |
| cmp_in | input | 1 | Comparator: 1 when the input is above the DAC level |
| dac_code | output | 10 | Trial code to the DAC |
| chan_sel | output | 2 | Analog multiplexer select |
| sample_hold | output | 1 | Sample-hold strobe |
| busy | output | 1 | Busy status flag |
| done | output | 1 | Conversion-complete flag |
| res_hi | output | 8 | Result bits 9:2 |
| res_lo | output | 2 | Result bits 1:0 |

## Verification
The bench builds the block with its default parameters: a 10-bit result, 2 initiation cycles, 8 sampling cycles, 4 cycles per bit and 2 closing cycles, so a conversion takes 52 ticks. It places a machine-cycle tick on every fourth clock. These values put every phase boundary, the tick-52 completion and the between-tick hold behaviour within a short run. The comparator is modelled from a chosen input level, so the extreme codes 0 and 1023 and the MSB boundary around 512 can be reached.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_SAMPLE,
        PH_TRIAL,
        PH_TAIL
    } phase_e;

endpackage

// File: rtl/sar_start_trig.sv
module sar_start_trig #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic sw_start,
    input  logic ext_en,
    input  logic ext_start,
    input  logic run,
    input  logic abort,
    output logic start_go
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   pin_prev;
        logic                   cmd;
    } trig_t;

    trig_t s_d, s_q;
    logic  ext_edge;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], ext_start};
        ext_edge = mc_tick && ext_en && s_q.sync[SYNC_STAGES-1] && !s_q.pin_prev;
        start_go = mc_tick && !run && !abort && (s_q.cmd || ext_edge);
        if (mc_tick) begin
            s_d.pin_prev = s_q.sync[SYNC_STAGES-1];
        end
        if (abort || start_go) begin
            s_d.cmd = 1'b0;
        end else if (sw_start && !run) begin
            s_d.cmd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/sar_phase_timer.sv
module sar_phase_timer
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_W    = 10,
    parameter int unsigned INIT_CYC = 2,
    parameter int unsigned SAMP_CYC = 8,
    parameter int unsigned BIT_CYC  = 4,
    parameter int unsigned TAIL_CYC = 2,
    localparam int unsigned BIT_BASE  = INIT_CYC + SAMP_CYC,
    localparam int unsigned TRIAL_END = BIT_BASE + RES_W * BIT_CYC,
    localparam int unsigned TOTAL     = TRIAL_END + TAIL_CYC,
    localparam int unsigned CNT_W     = $clog2(TOTAL + 1),
    localparam int unsigned SUB_W     = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1,
    localparam int unsigned IDX_W     = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic             start_go,
    input  logic             abort,
    output logic             run,
    output logic             busy,
    output phase_e           phase,
    output logic [IDX_W-1:0] bit_idx,
    output logic             decide,
    output logic             finish
);

    typedef struct packed {
        logic             run;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic [IDX_W-1:0] idx;
    } tmr_t;

    tmr_t t_d, t_q;
    logic last_sub;
    logic last_cyc;

    always_comb begin
        if (!t_q.run)                             phase = PH_IDLE;
        else if (t_q.cnt < CNT_W'(INIT_CYC))      phase = PH_INIT;
        else if (t_q.cnt < CNT_W'(BIT_BASE))      phase = PH_SAMPLE;
        else if (t_q.cnt < CNT_W'(TRIAL_END))     phase = PH_TRIAL;
        else                                      phase = PH_TAIL;

        last_sub = (t_q.sub == SUB_W'(BIT_CYC - 1));
        last_cyc = (t_q.cnt == CNT_W'(TOTAL - 1));
        decide   = t_q.run && mc_tick && !abort && (phase == PH_TRIAL) && last_sub;
        finish   = t_q.run && mc_tick && !abort && last_cyc;

        t_d = t_q;
        if (abort) begin
            t_d.run  = 1'b0;
            t_d.busy = 1'b0;
            t_d.cnt  = '0;
            t_d.sub  = '0;
            t_d.idx  = IDX_W'(RES_W - 1);
        end else if (start_go) begin
            t_d.run  = 1'b1;
            t_d.busy = 1'b0;
            t_d.cnt  = '0;
            t_d.sub  = '0;
            t_d.idx  = IDX_W'(RES_W - 1);
        end else if (t_q.run && mc_tick) begin
            t_d.cnt = t_q.cnt + 1'b1;
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b1;
            end
            if (phase == PH_TRIAL) begin
                if (last_sub) begin
                    t_d.sub = '0;
                    if (t_q.idx != '0) begin
                        t_d.idx = t_q.idx - 1'b1;
                    end
                end else begin
                    t_d.sub = t_q.sub + 1'b1;
                end
            end
            if (last_cyc) begin
                t_d.run  = 1'b0;
                t_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q     <= '0;
            t_q.idx <= IDX_W'(RES_W - 1);
        end else begin
            t_q <= t_d;
        end
    end

    assign run     = t_q.run;
    assign busy    = t_q.busy;
    assign bit_idx = t_q.idx;

    assert_busy_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.busy) |-> t_q.run && $past(t_q.run));

    assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !abort && !start_go) |=> $stable(t_q));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.run && mc_tick && !abort && !last_cyc) |=> (t_q.run && t_q.cnt == $past(t_q.cnt) + 1'b1));

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int unsigned RES_W = 10,
    localparam int unsigned IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_go,
    input  logic             abort,
    input  logic             in_trial,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             decide,
    input  logic             cmp_in,
    input  logic             finish,
    input  logic             done_clr,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             done
);

    typedef struct packed {
        logic [RES_W-1:0] sar;
        logic [RES_W-1:0] res;
        logic             done;
    } sar_t;

    sar_t             r_d, r_q;
    logic [RES_W-1:0] trial_mask;

    always_comb begin
        for (int i = 0; i < RES_W; i++) begin
            trial_mask[i] = in_trial && (bit_idx == IDX_W'(i));
        end

        r_d = r_q;
        if (start_go || abort) begin
            r_d.sar = '0;
        end else if (decide && cmp_in) begin
            r_d.sar = r_q.sar | trial_mask;
        end
        if (finish) begin
            r_d.res  = r_d.sar;
            r_d.done = 1'b1;
        end else if (done_clr) begin
            r_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dac_code = r_q.sar | trial_mask;
    assign result   = r_q.res;
    assign done     = r_q.done;

    assert_one_trial_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_trial |-> ($countones(trial_mask) == 1));

    assert_result_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(r_q.res));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_W       = 10,
    parameter int unsigned LO_W        = 2,
    parameter int unsigned CH_W        = 2,
    parameter int unsigned INIT_CYC    = 2,
    parameter int unsigned SAMP_CYC    = 8,
    parameter int unsigned BIT_CYC     = 4,
    parameter int unsigned TAIL_CYC    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned HI_W  = RES_W - LO_W,
    localparam int unsigned IDX_W = $clog2(RES_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              sw_start,
    input  logic              ext_en,
    input  logic              ext_start,
    input  logic              chan_wr,
    input  logic [CH_W-1:0]   chan_wdata,
    input  logic              done_clr,
    input  logic              lp_enter,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   chan_sel,
    output logic              sample_hold,
    output logic              busy,
    output logic              done,
    output logic [HI_W-1:0]   res_hi,
    output logic [LO_W-1:0]   res_lo
);

    logic             start_go;
    logic             run;
    logic             abort;
    phase_e           phase;
    logic [IDX_W-1:0] bit_idx;
    logic             decide;
    logic             finish;
    logic [RES_W-1:0] result;
    logic [CH_W-1:0]  chan_d, chan_q;

    assign abort = lp_enter && run;

    sar_start_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_tick  (mc_tick),
        .sw_start (sw_start),
        .ext_en   (ext_en),
        .ext_start(ext_start),
        .run      (run),
        .abort    (lp_enter),
        .start_go (start_go)
    );

    sar_phase_timer #(
        .RES_W   (RES_W),
        .INIT_CYC(INIT_CYC),
        .SAMP_CYC(SAMP_CYC),
        .BIT_CYC (BIT_CYC),
        .TAIL_CYC(TAIL_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .mc_tick (mc_tick),
        .start_go(start_go),
        .abort   (abort),
        .run     (run),
        .busy    (busy),
        .phase   (phase),
        .bit_idx (bit_idx),
        .decide  (decide),
        .finish  (finish)
    );

    sar_approx_reg #(.RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_go (start_go),
        .abort    (abort),
        .in_trial (phase == PH_TRIAL),
        .bit_idx  (bit_idx),
        .decide   (decide),
        .cmp_in   (cmp_in),
        .finish   (finish),
        .done_clr (done_clr),
        .dac_code (dac_code),
        .result   (result),
        .done     (done)
    );

    always_comb begin
        chan_d = chan_q;
        if (chan_wr) begin
            chan_d = chan_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_d;
        end
    end

    assign chan_sel    = chan_q;
    assign sample_hold = (phase == PH_SAMPLE);
    assign res_hi      = result[RES_W-1:LO_W];
    assign res_lo      = result[LO_W-1:0];

    assert_quiet_dac_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> (dac_code == '0));

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_enter && !finish) |=> (!busy && !$rose(done)));

endmodule

// File: tb/tb_sar_conv_seq.sv
`timescale 1ns/1ps
module tb_sar_conv_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       sw_start = 1'b0;
    logic       ext_en = 1'b0;
    logic       ext_start = 1'b0;
    logic       chan_wr = 1'b0;
    logic [1:0] chan_wdata = 2'd0;
    logic       done_clr = 1'b0;
    logic       lp_enter = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [1:0] chan_sel;
    logic       sample_hold, busy, done;
    logic [7:0] res_hi;
    logic [1:0] res_lo;
    logic [9:0] vin = 10'd0;

    int tests = 0;
    int fails = 0;
    logic [9:0] exp_q[$];

    assign cmp_in = (vin > dac_code);

    always #2.5 clk = ~clk;

    sar_conv_seq dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .sw_start(sw_start),
        .ext_en(ext_en), .ext_start(ext_start), .chan_wr(chan_wr),
        .chan_wdata(chan_wdata), .done_clr(done_clr), .lp_enter(lp_enter),
        .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel),
        .sample_hold(sample_hold), .busy(busy), .done(done),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            mc_tick = 1'b1;
            @(negedge clk);
            mc_tick = 1'b0;
        end
    end

    task automatic wait_tick();
        @(posedge clk);
        while (!mc_tick) @(posedge clk);
        #1;
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
    endtask

    function automatic int model_res(input int v);
        return (v == 0) ? 0 : v - 1;
    endfunction

    // Monitor: pop the expected result when done rises
    initial begin
        logic done_seen;
        logic [9:0] e;
        done_seen = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (done && !done_seen) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected completion", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R5 result value", {res_hi, res_lo}, e);
                    chk("R7 upper byte", res_hi, e[9:2]);
                    chk("R7 low bits", res_lo, e[1:0]);
                end
            end
            done_seen = done;
        end
    end

    // Driver: one full conversion, optional start injection while running
    task automatic run_conv(input int v, input bit use_ext, input bit inject, input string tag);
        int e;
        int hi;
        vin = v[9:0];
        e = model_res(v);
        exp_q.push_back(e[9:0]);
        wait_tick();
        if (use_ext) begin
            @(negedge clk) ext_start = 1'b1;
        end else begin
            pulse_sw();
        end
        wait_tick();
        chk({tag, " R3 busy low at start tick"}, busy, 0);
        for (int k = 1; k <= 52; k++) begin
            wait_tick();
            if (k == 3) ext_start = 1'b0;
            if (inject && k == 20) begin
                ext_start = 1'b1;
                pulse_sw();
            end
            if (inject && k == 24) ext_start = 1'b0;
            chk({tag, " R3 busy"}, busy, (k < 52) ? 1 : 0);
            chk({tag, " R6 done"}, done, (k == 52) ? 1 : 0);
            chk({tag, " R4 sample strobe"}, sample_hold, (k >= 2 && k <= 9) ? 1 : 0);
            if (k >= 10 && k < 50 && ((k - 10) % 4) == 0) begin
                int j;
                j = (k - 10) / 4;
                hi = (e & (32'h3FF << (10 - j))) & 32'h3FF;
                chk({tag, " R5 trial code"}, dac_code, hi | (1 << (9 - j)));
            end
            if (k == 51) begin
                repeat (2) @(posedge clk);
                #1;
                chk({tag, " R6 no early done"}, done, 0);
            end
        end
    endtask

    task automatic clear_done();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        #1;
        chk("R11 done cleared", done, 0);
    endtask

    task automatic abort_conv(input int v, input int done_exp, input int res_exp);
        vin = v[9:0];
        wait_tick();
        pulse_sw();
        for (int k = 0; k <= 20; k++) wait_tick();
        chk("R10 busy before abort", busy, 1);
        @(negedge clk) lp_enter = 1'b1;
        @(negedge clk) lp_enter = 1'b0;
        #1;
        chk("R10 busy after abort", busy, 0);
        for (int k = 0; k < 60; k++) wait_tick();
        chk("R10 no done after abort", done, done_exp);
        chk("R10 result kept", {res_hi, res_lo}, res_exp);
        chk("R10 stays idle", busy, 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        chk("R12 busy", busy, 0);
        chk("R12 done", done, 0);
        chk("R12 sample", sample_hold, 0);
        chk("R12 dac", dac_code, 0);
        chk("R12 result", {res_hi, res_lo}, 0);
        chk("R12 chan", chan_sel, 0);
        @(negedge clk) rst_n = 1'b1;

        @(negedge clk) begin chan_wr = 1'b1; chan_wdata = 2'd3; end
        @(negedge clk) chan_wr = 1'b0;
        #1;
        chk("R8 channel 3", chan_sel, 3);
        @(negedge clk) begin chan_wr = 1'b1; chan_wdata = 2'd1; end
        @(negedge clk) chan_wr = 1'b0;
        #1;
        chk("R8 channel 1", chan_sel, 1);

        ext_en = 1'b1;
        run_conv(700, 1'b0, 1'b0, "R1 sw start with ext_en");
        clear_done();
        run_conv(300, 1'b1, 1'b0, "R2 ext start");
        clear_done();

        ext_en = 1'b0;
        wait_tick();
        @(negedge clk) ext_start = 1'b1;
        for (int k = 0; k < 3; k++) wait_tick();
        ext_start = 1'b0;
        for (int k = 0; k < 6; k++) wait_tick();
        chk("R2 pin ignored when disabled busy", busy, 0);
        chk("R2 pin ignored when disabled done", done, 0);

        run_conv(0, 1'b0, 1'b0, "R5 zero");
        clear_done();
        run_conv(1023, 1'b0, 1'b0, "R5 full");
        clear_done();
        run_conv(513, 1'b0, 1'b0, "R5 above mid");
        clear_done();
        run_conv(512, 1'b0, 1'b0, "R5 at mid");
        clear_done();

        ext_en = 1'b1;
        run_conv(100, 1'b0, 1'b1, "R9 restart ignored");
        for (int k = 0; k < 8; k++) wait_tick();
        chk("R9 no queued restart", busy, 0);
        chk("R9 done held", done, 1);
        clear_done();
        ext_en = 1'b0;

        run_conv(900, 1'b0, 1'b0, "R10 setup");
        @(negedge clk) lp_enter = 1'b1;
        @(negedge clk) lp_enter = 1'b0;
        #1;
        chk("R10 idle entry keeps done", done, 1);
        chk("R10 idle entry keeps result", {res_hi, res_lo}, 899);
        abort_conv(5, 1, 899);
        clear_done();
        abort_conv(40, 0, 899);

        chk("R6 scoreboard drained", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule